// File: doc/BRIEF.md
# Packed Lane Shift, Rotate and Shuffle Unit

This block processes one 64-bit operand per cycle. It treats the operand as four 16-bit lanes, two 32-bit lanes or one 64-bit lane, and shifts or rotates every lane by the same scalar amount. Bits never move from one lane into another. The same datapath also has two permutation operations:

- A halfword shuffle, which builds each destination halfword from any source halfword under an 8-bit control.
- A byte-granular funnel align, which cuts a 64-bit window out of the 128-bit pair formed by two operands.

Each accepted operation produces a registered 64-bit result and a 32-bit packed flag word. The flag word holds a negative bit and a zero bit for every lane at the lane width of the operation. The block sits behind an instruction decoder, which supplies the operation code, lane width, operands and scalar. Results come out one cycle later with a valid strobe.

Top module: `pk_shift_unit`

## Requirements
- R1: `op` selects the operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 halfword shuffle, 5 align. `lane_sel` selects the lane width: 0 is 16 bits, 1 is 32 bits, 2 or 3 is 64 bits. For amounts below the lane width, each lane of `opa` is shifted by `amount` with no bits crossing a lane boundary.
- R2: A logical shift (left or right) whose `amount` is greater than or equal to the lane width returns zero in that lane.
- R3: Arithmetic right shift fills the vacated bits of each lane with that lane's own top bit. When `amount` is at least the lane width, the whole lane equals its sign bit.
- R4: Rotate right uses `amount` modulo the lane width, r, and gives (x >> r) | (x << (W − r)) within the lane. When r is 0 the lane is returned unchanged.
- R5: For shuffle, destination halfword i (bits 16i+15:16i) takes source halfword k of `opa`, where k is `amount[2i+1:2i]`.
- R6: For align, n = `amount[2:0]` and the result is (`opa` >> 8n) | (`opb` << (64 − 8n)). When n = 0 the result is exactly `opa`. The upper bits of `amount` are ignored.
- R7: The flag word splits into equal groups, one per lane, with lane 0 in the lowest group. In each group the top bit is the lane's most significant result bit and the bit below it is set when the lane is all zero. All other bits are 0. Shifts and rotates use the selected lane width, shuffle uses 16-bit lanes, and align and reserved codes use one 64-bit lane (bits 31 and 30).
- R8: `out_valid` rises in the cycle after an edge at which `in_valid` was high, and is low after any edge where it was low. `result` and `flags` keep their values while `in_valid` is low.
- R9: While `rst_n` is low, `out_valid` is low.
- R10: Operation codes 6 and 7 pass `opa` to `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted on this edge |
| op | input | 3 | Operation code |
| lane_sel | input | 2 | Lane width select |
| opa | input | 64 | Primary operand |
| opb | input | 64 | Second operand (align only) |
| amount | input | 8 | Shift/rotate amount, shuffle control, or align byte count |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 64 | Registered result |
| flags | output | 32 | Registered packed N/Z flag word |

## Verification
The hardest cases to reach are amounts at and just past each lane width. These are where logical shifts must collapse to zero, arithmetic shifts must saturate to the sign, and rotates must wrap. They are also where a lane-boundary leak would show, which only happens when a lane's top bits and its neighbour's bottom bits differ. The stimulus therefore sweeps every amount from 0 through 71, plus a few large values, for every shift mode and every lane width. It uses operands whose lanes mix set sign bits, all-zero lanes and alternating patterns. All 256 shuffle controls and every align byte count are applied, including controls with the upper `amount` bits set.

// File: rtl/pk_shift_pkg.sv
package pk_shift_pkg;

  typedef enum logic [2:0] {
    OP_SLL   = 3'd0,
    OP_SRL   = 3'd1,
    OP_SRA   = 3'd2,
    OP_ROR   = 3'd3,
    OP_SHUF  = 3'd4,
    OP_ALIGN = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } pk_op_e;

  typedef enum logic [1:0] {
    LW_16  = 2'd0,
    LW_32  = 2'd1,
    LW_64  = 2'd2,
    LW_64X = 2'd3
  } pk_lw_e;

endpackage

// File: rtl/pk_lane_shifter.sv
module pk_lane_shifter
  import pk_shift_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int AMT_W  = 8
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic [AMT_W-1:0]  amount,
  input  pk_op_e            op,
  output logic [LANE_W-1:0] lane_out
);
  localparam int SH_W = $clog2(LANE_W);

  logic              amt_wide;
  logic [SH_W-1:0]   sh;
  logic [SH_W:0]     back_sh;
  logic [LANE_W-1:0] sll_v, srl_v, sra_v, ror_v;

  assign amt_wide = (amount >= AMT_W'(LANE_W));
  assign sh       = amount[SH_W-1:0];
  assign back_sh  = (SH_W+1)'(LANE_W) - {1'b0, sh};

  always_comb begin
    sll_v = amt_wide ? '0 : (lane_in << sh);
    srl_v = amt_wide ? '0 : (lane_in >> sh);
    sra_v = amt_wide ? {LANE_W{lane_in[LANE_W-1]}}
                     : LANE_W'($signed(lane_in) >>> sh);
    ror_v = (sh == '0) ? lane_in : ((lane_in >> sh) | (lane_in << back_sh));
  end

  always_comb begin
    unique case (op)
      OP_SLL:  lane_out = sll_v;
      OP_SRL:  lane_out = srl_v;
      OP_SRA:  lane_out = sra_v;
      OP_ROR:  lane_out = ror_v;
      default: lane_out = lane_in;
    endcase
  end

endmodule

// File: rtl/pk_permute.sv
module pk_permute #(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] shuf_res,
  output logic [DATA_W-1:0] align_res
);
  localparam int HW_W   = 16;
  localparam int NUM_HW = DATA_W / HW_W;
  localparam int SEL_W  = $clog2(NUM_HW);
  localparam int NB_W   = $clog2(DATA_W / 8);
  localparam int SH_W   = $clog2(DATA_W) + 1;

  for (genvar i = 0; i < NUM_HW; i++) begin : g_hw
    logic [SEL_W-1:0] pick;
    assign pick = ctrl[SEL_W*i +: SEL_W];
    assign shuf_res[HW_W*i +: HW_W] = opa[pick*HW_W +: HW_W];
  end

  logic [NB_W-1:0] byte_n;
  logic [SH_W-1:0] lo_sh, hi_sh;

  assign byte_n = ctrl[NB_W-1:0];
  assign lo_sh  = SH_W'({byte_n, 3'b000});
  assign hi_sh  = SH_W'(DATA_W) - lo_sh;

  always_comb begin
    if (byte_n == '0) align_res = opa;
    else              align_res = (opa >> lo_sh) | (opb << hi_sh);
  end

endmodule

// File: rtl/pk_flag_pack.sv
module pk_flag_pack
  import pk_shift_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]   res,
  input  pk_lw_e              fw,
  output logic [DATA_W/2-1:0] flags
);
  localparam int FLAG_W = DATA_W / 2;
  localparam int NUM_G  = 3;

  logic [NUM_G-1:0][FLAG_W-1:0] cand;

  for (genvar g = 0; g < NUM_G; g++) begin : g_width
    localparam int LW    = 16 << g;
    localparam int LANES = DATA_W / LW;
    localparam int GRP   = FLAG_W / LANES;
    logic [FLAG_W-1:0] c;
    always_comb begin
      c = '0;
      for (int l = 0; l < LANES; l++) begin
        c[GRP*(l+1)-1] = res[LW*(l+1)-1];
        c[GRP*(l+1)-2] = ~|res[LW*l +: LW];
      end
    end
    assign cand[g] = c;
  end

  always_comb begin
    unique case (fw)
      LW_16:   flags = cand[0];
      LW_32:   flags = cand[1];
      default: flags = cand[2];
    endcase
  end

endmodule

// File: rtl/pk_shift_unit.sv
module pk_shift_unit
  import pk_shift_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int AMT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          op,
  input  logic [1:0]          lane_sel,
  input  logic [DATA_W-1:0]   opa,
  input  logic [DATA_W-1:0]   opb,
  input  logic [AMT_W-1:0]    amount,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic [DATA_W/2-1:0] flags
);
  localparam int FLAG_W = DATA_W / 2;
  localparam int NUM_G  = 3;
  localparam int CTRL_W = 2 * (DATA_W / 16);
  localparam logic [FLAG_W-1:0] NZ_POS = {(FLAG_W/8){8'hC0}};

  pk_op_e op_e;
  pk_lw_e lw_e;
  assign op_e = pk_op_e'(op);
  assign lw_e = pk_lw_e'(lane_sel);

  // lane-confined shifters, one set per lane width
  logic [NUM_G-1:0][DATA_W-1:0] shf_res;

  for (genvar g = 0; g < NUM_G; g++) begin : g_width
    localparam int LW    = 16 << g;
    localparam int LANES = DATA_W / LW;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      pk_lane_shifter #(.LANE_W(LW), .AMT_W(AMT_W)) u_lane (
        .lane_in  (opa[LW*l +: LW]),
        .amount   (amount),
        .op       (op_e),
        .lane_out (shf_res[g][LW*l +: LW])
      );
    end
  end

  logic [DATA_W-1:0] shuf_res, align_res;

  pk_permute #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_perm (
    .opa       (opa),
    .opb       (opb),
    .ctrl      (amount[CTRL_W-1:0]),
    .shuf_res  (shuf_res),
    .align_res (align_res)
  );

  // next-state selection
  logic [DATA_W-1:0] res_nxt;
  pk_lw_e            fw_nxt;
  logic [FLAG_W-1:0] flags_nxt;

  always_comb begin
    unique case (op_e)
      OP_SLL, OP_SRL, OP_SRA, OP_ROR: begin
        fw_nxt = lw_e;
        unique case (lw_e)
          LW_16:   res_nxt = shf_res[0];
          LW_32:   res_nxt = shf_res[1];
          default: res_nxt = shf_res[2];
        endcase
      end
      OP_SHUF: begin
        res_nxt = shuf_res;
        fw_nxt  = LW_16;
      end
      OP_ALIGN: begin
        res_nxt = align_res;
        fw_nxt  = LW_64;
      end
      default: begin
        res_nxt = opa;
        fw_nxt  = LW_64;
      end
    endcase
  end

  pk_flag_pack #(.DATA_W(DATA_W)) u_flags (
    .res   (res_nxt),
    .fw    (fw_nxt),
    .flags (flags_nxt)
  );

  // registers
  logic              vld_q;
  logic [DATA_W-1:0] res_q;
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      res_q   <= res_nxt;
      flags_q <= flags_nxt;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign flags     = flags_q;

  // assertions
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> !out_valid); // R9
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flags))); // R8
  AST_SLL_WIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SLL && amount >= AMT_W'(DATA_W)) |=> (result == '0)); // R2
  AST_ROR_FULL_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ROR && amount[$clog2(DATA_W)-1:0] == '0)
      |=> (result == $past(opa))); // R4
  AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ALIGN && amount[2:0] == 3'd0) |=> (result == $past(opa))); // R6
  AST_RSV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[2:1] == 2'b11) |=> (result == $past(opa))); // R10
  AST_FLAG_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((flags & ~NZ_POS) == '0)); // R7

endmodule

// File: tb/tb_pk_shift_unit.sv
module tb_pk_shift_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [1:0]  lane_sel;
  logic [63:0] opa, opb;
  logic [7:0]  amount;
  logic        out_valid;
  logic [63:0] result;
  logic [31:0] flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  pk_shift_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sel(lane_sel),
    .opa(opa), .opb(opb), .amount(amount), .out_valid(out_valid),
    .result(result), .flags(flags)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic int lane_w(input logic [1:0] sel);
    return (sel == 2'd0) ? 16 : (sel == 2'd1) ? 32 : 64;
  endfunction

  function automatic logic [63:0] wmask(input int w);
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] ref_res(input logic [2:0] o, input logic [1:0] sel,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input logic [7:0] amt);
    logic [63:0] r, m, x, y;
    int w, r_amt, n, k;
    r = '0;
    if (o <= 3'd3) begin
      w = lane_w(sel);
      m = wmask(w);
      for (int l = 0; l < 64 / w; l++) begin
        x = (a >> (l * w)) & m;
        case (o)
          3'd0: y = (amt >= w) ? 64'd0 : ((x << amt) & m);
          3'd1: y = (amt >= w) ? 64'd0 : (x >> amt);
          3'd2: begin
            if (amt >= w) y = x[w-1] ? m : 64'd0;
            else y = (x >> amt) | (x[w-1] ? (m & ~(m >> amt)) : 64'd0);
          end
          default: begin
            r_amt = amt % w;
            y = (r_amt == 0) ? x : (((x >> r_amt) | (x << (w - r_amt))) & m);
          end
        endcase
        r = r | (y << (l * w));
      end
    end else if (o == 3'd4) begin
      for (int i = 0; i < 4; i++) begin
        k = (amt >> (2 * i)) & 3;
        r[16*i +: 16] = a[16*k +: 16];
      end
    end else if (o == 3'd5) begin
      n = amt & 7;
      r = (n == 0) ? a : ((a >> (8 * n)) | (b << (64 - 8 * n)));
    end else begin
      r = a;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_flags(input logic [2:0] o, input logic [1:0] sel,
                                            input logic [63:0] r);
    logic [31:0] f;
    int w, g;
    w = (o <= 3'd3) ? lane_w(sel) : (o == 3'd4) ? 16 : 64;
    g = w / 2;
    f = '0;
    for (int l = 0; l < 64 / w; l++) begin
      f[g*(l+1)-1] = r[w*(l+1)-1];
      f[g*(l+1)-2] = ((r >> (w * l)) & wmask(w)) == 64'd0;
    end
    return f;
  endfunction

  function automatic string tag_of(input logic [2:0] o, input logic [1:0] sel,
                                   input logic [7:0] amt);
    case (o)
      3'd0, 3'd1: return (amt >= lane_w(sel)) ? "R2" : "R1";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [1:0] sel,
                        input logic [63:0] a, input logic [63:0] b, input logic [7:0] amt);
    logic [63:0] er;
    logic [31:0] ef;
    @(negedge clk);
    in_valid = 1; op = o; lane_sel = sel; opa = a; opb = b; amount = amt;
    er = ref_res(o, sel, a, b, amt);
    ef = ref_flags(o, sel, er);
    @(negedge clk);
    n_checks++;
    if (result !== er || out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL %s op=%0d sel=%0d amt=%0d a=%h: result %h valid %b expected %h valid 1",
               tag_of(o, sel, amt), o, sel, amt, a, result, out_valid, er);
    end
    n_checks++;
    if (flags !== ef) begin
      n_fail++;
      $display("FAIL R7 op=%0d sel=%0d amt=%0d: flags %h expected %h", o, sel, amt, flags, ef);
    end
  endtask

  logic [63:0] pats [4];

  initial begin
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'h8000_0000_FFFF_0001;
    pats[2] = 64'h0000_0000_0000_0000;
    pats[3] = 64'hF0F0_0F0F_8000_7FFF;
  end

  initial begin
    logic [63:0] held_r;
    logic [31:0] held_f;
    rst_n = 0; in_valid = 0; op = 0; lane_sel = 0; opa = '0; opb = '0; amount = '0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset: out_valid %b expected 0", out_valid);
    end
    rst_n = 1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 idle after reset: out_valid %b expected 0", out_valid);
    end

    // shifts and rotates: every width, amounts through and beyond each lane size
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 4; o++)
        for (int s = 0; s < 4; s++)
          for (int k = 0; k < 75; k++)
            run_op(3'(o), 2'(s), pats[p], pats[(p + 1) % 4],
                   (k < 72) ? 8'(k) : (k == 72) ? 8'd128 : (k == 73) ? 8'd200 : 8'd255);

    // shuffle: every control value
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 256; c++)
        run_op(3'd4, 2'(c % 4), pats[p] ^ 64'h1111_2222_3333_4444, pats[3 - p], 8'(c));

    // align: every byte count, with and without upper amount bits
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 16; c++)
        run_op(3'd5, 2'd0, pats[p], ~pats[(p + 2) % 4], (c < 8) ? 8'(c) : 8'(c | 8'hF0));

    // reserved codes R10
    for (int p = 0; p < 4; p++) begin
      run_op(3'd6, 2'd1, pats[p], pats[0], 8'd3);
      run_op(3'd7, 2'd0, pats[p], pats[1], 8'd40);
    end

    // hold while idle R8
    run_op(3'd3, 2'd0, 64'hDEAD_BEEF_0000_8001, '0, 8'd4);
    held_r = result;
    held_f = flags;
    @(negedge clk);
    in_valid = 0; op = 3'd0; opa = 64'hFFFF_FFFF_FFFF_FFFF; amount = 8'd1;
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== held_r || flags !== held_f) begin
      n_fail++;
      $display("FAIL R8 hold: valid %b result %h flags %h expected 0 %h %h",
               out_valid, result, flags, held_r, held_f);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule